// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block paces periodic auto-refresh commands for a DRAM channel so that a fixed number of refreshes, spread evenly, covers every row once per retention window. A free-running interval timer marks when a refresh falls due. Each due refresh is added to a small count of owed refreshes. While at least one refresh is owed, the block raises a request toward the normal-traffic arbiter. A grant retires one owed refresh, so refreshes are slotted in between ordinary commands one at a time rather than issued as a burst.

Each accepted refresh uses the current value of an internal row counter. The counter then steps forward and wraps after a programmable last index. A one-cycle pulse marks the end of each full sweep. After every refresh, an activate-inhibit output stays high for a programmable refresh cycle time. The request is withheld until that time has passed. When too many refreshes pile up without a grant, an urgent flag tells the arbiter to give refresh priority.

All timing is programmable in clock cycles. With a 64 ms window and 8192 refreshes, the interval is the window divided by 8192, converted to cycles. The refresh cycle time is likewise the cycle count of, for example, 260 ns.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, ref_req, ref_urgent, act_inhibit and sweep_done are 0 and ref_row is 0.
- R2: A refresh falls due every cfg_interval cycles, counted from reset release. The first one makes ref_req visible after the cfg_interval-th rising edge. A value of 0 or 1 means every cycle.
- R3: A refresh is accepted on a rising edge where ref_req and ref_grant are both 1, and it retires exactly one owed refresh. A ref_grant that arrives while ref_req is 0 changes neither ref_row nor the lockout timing.
- R4: Each accepted refresh advances ref_row by one. The refresh that uses row cfg_last_row sets ref_row back to 0.
- R5: sweep_done is high for exactly one cycle, the cycle after the accepted refresh that used row cfg_last_row.
- R6: After an accepted refresh, act_inhibit is high for exactly cfg_trfc cycles. With cfg_trfc = 0 it does not rise.
- R7: ref_req stays 0 while act_inhibit is 1, so no two refreshes are accepted less than cfg_trfc cycles apart.
- R8: ref_urgent is 1 exactly when the number of owed refreshes is greater than cfg_urgent_limit.
- R9: The owed count saturates at 2^PEND_W-1 (15 by default). After a long stall with no grants, exactly that many refreshes are accepted before ref_req drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | CNT_W | Cycles between refreshes falling due |
| cfg_last_row | input | ROW_W | Last row index before the row counter wraps |
| cfg_trfc | input | TRFC_W | Activate lockout length after each refresh, in cycles |
| cfg_urgent_limit | input | PEND_W | Owed-refresh count above which urgent is raised |
| ref_grant | input | 1 | Arbiter grant of the command bus for a refresh |
| ref_req | output | 1 | A refresh is owed and may be issued |
| ref_urgent | output | 1 | Too many refreshes are owed; refresh must take priority |
| ref_row | output | ROW_W | Row the next refresh will act on |
| sweep_done | output | 1 | One-cycle pulse after the last row of a sweep is refreshed |
| act_inhibit | output | 1 | ACTIVATE commands are blocked |

## Verification
The bench measures the exact cycle in which the first and the following refreshes fall due. A design off by one in the interval compare would report a count of 9 or 11 instead of 10. A grant is injected while the lockout is running. A design that accepts it would advance the row or restart the lockout, and the bench sees this as a wrong row or an inhibit longer than cfg_trfc. A long stall without grants drives the owed count into saturation. The bench then drains it and expects exactly 15 refreshes. A counter that wraps would give fewer, and one that does not saturate would give more. It also checks that the drain runs with cfg_trfc = 0 and that the row counter wraps with a one-cycle sweep pulse.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    // Default sizing shared by the scheduler and its parts
    parameter int unsigned RF_ROWS_DEF   = 8192;
    parameter int unsigned RF_CNT_W_DEF  = 24;
    parameter int unsigned RF_TRFC_W_DEF = 12;
    parameter int unsigned RF_PEND_W_DEF = 4;

    // What the owed-refresh counter does on one edge
    typedef enum logic [1:0] {
        OWED_HOLD = 2'd0,
        OWED_INC  = 2'd1,
        OWED_DEC  = 2'd2
    } owed_op_e;

endpackage

// File: rtl/refresh_pacer.sv
module refresh_pacer
    import refresh_pkg::*;
#(
    parameter int unsigned CNT_W  = RF_CNT_W_DEF,
    parameter int unsigned PEND_W = RF_PEND_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic [PEND_W-1:0] cfg_urgent_limit,
    input  logic              issue,
    output logic              owed_nz,
    output logic              urgent
);
    localparam logic [PEND_W-1:0] OWED_MAX = {PEND_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PEND_W-1:0] owed;
    } pacer_st_t;

    pacer_st_t st_d, st_q;
    logic      tick;
    owed_op_e  op;

    always_comb begin
        st_d = st_q;
        tick = (cfg_interval <= CNT_W'(1)) || (st_q.cnt >= cfg_interval - CNT_W'(1));
        st_d.cnt = tick ? '0 : st_q.cnt + CNT_W'(1);
        if (tick && !issue) begin
            op = OWED_INC;
        end else if (issue && !tick) begin
            op = OWED_DEC;
        end else begin
            op = OWED_HOLD;
        end
        unique case (op)
            OWED_INC: if (st_q.owed != OWED_MAX) st_d.owed = st_q.owed + PEND_W'(1);
            OWED_DEC: st_d.owed = st_q.owed - PEND_W'(1);
            default:  st_d.owed = st_q.owed;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owed_nz = (st_q.owed != '0);
    assign urgent  = (st_q.owed > cfg_urgent_limit);

    AST_ISSUE_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (st_q.owed != '0)); // R3

    AST_OWED_RETIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !tick) |=> (st_q.owed == $past(st_q.owed) - PEND_W'(1))); // R3

    AST_OWED_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.owed) == OWED_MAX && !$past(issue)) |-> (st_q.owed == OWED_MAX)); // R9

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int unsigned ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] cfg_last_row,
    input  logic             issue,
    output logic [ROW_W-1:0] row,
    output logic             sweep_done
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             sweep;
    } row_st_t;

    row_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        st_d     = st_q;
        at_last  = (st_q.row == cfg_last_row);
        st_d.sweep = issue && at_last;
        if (issue) begin
            st_d.row = at_last ? '0 : st_q.row + ROW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row        = st_q.row;
    assign sweep_done = st_q.sweep;

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(st_q.row)); // R4

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && st_q.row != cfg_last_row) |=> (st_q.row == $past(st_q.row) + ROW_W'(1))); // R4

    AST_SWEEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sweep |=> !st_q.sweep || $past(issue)); // R5

endmodule

// File: rtl/refresh_lockout.sv
module refresh_lockout #(
    parameter int unsigned TRFC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRFC_W-1:0] cfg_trfc,
    input  logic              issue,
    output logic              locked
);
    typedef struct packed {
        logic [TRFC_W-1:0] left;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue) begin
            st_d.left = cfg_trfc;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - TRFC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = (st_q.left != '0);

    AST_LOCK_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !issue) |=> (st_q.left < $past(st_q.left))); // R6

    AST_LOCK_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (st_q.left == $past(cfg_trfc))); // R6

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_pkg::*;
#(
    parameter int unsigned ROWS   = RF_ROWS_DEF,
    parameter int unsigned CNT_W  = RF_CNT_W_DEF,
    parameter int unsigned TRFC_W = RF_TRFC_W_DEF,
    parameter int unsigned PEND_W = RF_PEND_W_DEF,
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic [ROW_W-1:0]  cfg_last_row,
    input  logic [TRFC_W-1:0] cfg_trfc,
    input  logic [PEND_W-1:0] cfg_urgent_limit,
    input  logic              ref_grant,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [ROW_W-1:0]  ref_row,
    output logic              sweep_done,
    output logic              act_inhibit
);
    logic owed_nz;
    logic locked;
    logic issue;

    assign ref_req     = owed_nz && !locked;
    assign issue       = ref_req && ref_grant;
    assign act_inhibit = locked;

    refresh_pacer #(
        .CNT_W  (CNT_W),
        .PEND_W (PEND_W)
    ) u_pacer (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_interval     (cfg_interval),
        .cfg_urgent_limit (cfg_urgent_limit),
        .issue            (issue),
        .owed_nz          (owed_nz),
        .urgent           (ref_urgent)
    );

    refresh_row_ctr #(
        .ROW_W (ROW_W)
    ) u_rows (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_last_row (cfg_last_row),
        .issue        (issue),
        .row          (ref_row),
        .sweep_done   (sweep_done)
    );

    refresh_lockout #(
        .TRFC_W (TRFC_W)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_trfc (cfg_trfc),
        .issue    (issue),
        .locked   (locked)
    );

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cfg_trfc != '0) |=> !ref_req); // R7

    AST_INHIBIT_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cfg_trfc != '0) |=> act_inhibit); // R6

    AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !act_inhibit) |-> ref_req); // R8

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
    localparam int unsigned ROW_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [23:0]      cfg_interval = 24'd10;
    logic [ROW_W-1:0] cfg_last_row = 13'd3;
    logic [11:0]      cfg_trfc = 12'd5;
    logic [3:0]       cfg_urgent_limit = 4'd2;
    logic             ref_grant = 1'b0;
    logic             ref_req, ref_urgent, sweep_done, act_inhibit;
    logic [ROW_W-1:0] ref_row;

    int checks = 0;
    int fails  = 0;
    int exp_row = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    refresh_sched u_refresh_sched (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_interval     (cfg_interval),
        .cfg_last_row     (cfg_last_row),
        .cfg_trfc         (cfg_trfc),
        .cfg_urgent_limit (cfg_urgent_limit),
        .ref_grant        (ref_grant),
        .ref_req          (ref_req),
        .ref_urgent       (ref_urgent),
        .ref_row          (ref_row),
        .sweep_done       (sweep_done),
        .act_inhibit      (act_inhibit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        exp_row = 0;
    endtask

    // Issue one refresh; caller is at a negedge with ref_req high
    task automatic do_grant();
        ref_grant = 1'b1;
        step();
        ref_grant = 1'b0;
        exp_row = (exp_row == int'(cfg_last_row)) ? 0 : exp_row + 1;
    endtask

    task automatic wait_req(output int k);
        k = 0;
        for (int i = 0; i < 2000; i++) begin
            if (ref_req) break;
            step();
            k++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check(ref_req == 0,     "R1 req",     int'(ref_req), 0);
        check(ref_urgent == 0,  "R1 urgent",  int'(ref_urgent), 0);
        check(act_inhibit == 0, "R1 inhibit", int'(act_inhibit), 0);
        check(sweep_done == 0,  "R1 sweep",   int'(sweep_done), 0);
        check(ref_row == 0,     "R1 row",     int'(ref_row), 0);
        rst_n = 1'b1;
        exp_row = 0;
    endtask

    task automatic t_interval();
        int k;
        wait_req(k);
        check(k == 10, "R2 first due", k, 10);
        do_grant();
        check(int'(ref_row) == exp_row, "R4 row step", int'(ref_row), exp_row);
        k = 0;
        for (int i = 0; i < 100; i++) begin
            if (ref_req) break;
            step();
            k++;
        end
        check(k == 9, "R2 next due after grant", k, 9);
    endtask

    task automatic t_lockout();
        int hi = 0;
        int bad = 0;
        repeat (10) step();
        do_grant();
        for (int i = 0; i < 20; i++) begin
            if (!act_inhibit) break;
            hi++;
            if (ref_req) bad++;
            ref_grant = (i == 2);
            step();
        end
        ref_grant = 1'b0;
        check(hi == 5, "R6 inhibit length", hi, 5);
        check(bad == 0, "R7 req during lockout", bad, 0);
        check(int'(ref_row) == exp_row, "R3 stray grant ignored", int'(ref_row), exp_row);
        check(ref_req == 1, "R3 owed refresh remains", int'(ref_req), 1);
    endtask

    task automatic t_sweep();
        int k;
        wait_req(k);
        do_grant();
        check(int'(ref_row) == 3, "R4 row before wrap", int'(ref_row), 3);
        check(sweep_done == 0, "R5 no early sweep", int'(sweep_done), 0);
        wait_req(k);
        do_grant();
        check(ref_row == 0, "R4 wrap to zero", int'(ref_row), 0);
        check(sweep_done == 1, "R5 sweep pulse", int'(sweep_done), 1);
        step();
        check(sweep_done == 0, "R5 sweep one cycle", int'(sweep_done), 0);
    endtask

    task automatic t_urgent();
        int k = 0;
        int at20 = -1;
        do_reset();
        for (int i = 0; i < 200; i++) begin
            if (ref_urgent) break;
            if (k == 20) at20 = int'(ref_urgent);
            step();
            k++;
        end
        check(k == 30, "R8 urgent at limit+1 owed", k, 30);
        check(at20 == 0, "R8 urgent low at limit", at20, 0);
    endtask

    task automatic t_saturate();
        int n = 0;
        int inh = 0;
        repeat (200) step();
        cfg_interval = 24'd1000;
        cfg_trfc = 12'd0;
        for (int i = 0; i < 60; i++) begin
            if (!ref_req) break;
            do_grant();
            n++;
            if (act_inhibit) inh++;
        end
        check(n == 15, "R9 saturated drain", n, 15);
        check(inh == 0, "R6 zero trfc no inhibit", inh, 0);
        check(int'(ref_row) == exp_row, "R4 row after drain", int'(ref_row), exp_row);
        check(ref_urgent == 0, "R8 urgent clear after drain", int'(ref_urgent), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_interval();
        t_lockout();
        t_sweep();
        t_urgent();
        t_saturate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule